// File: doc/BRIEF.md
# RLE Compressed Logic Capture Core

This block is a triggered capture engine for a logic analyzer. On every clock it can sample a bank of event inputs, one to four bytes wide, and it stores them in on-chip RAM as run-length entries. Each entry holds one input value and the number of consecutive samples for which that value held. A signal that changes rarely therefore covers a long stretch of time in a small memory. In the same acquisition, an optional set of wide data lanes is captured without compression. These lanes are organised in groups of four 32-bit words, and they are kept in a circular window that ends up centred on the trigger sample.

A host controls the block over a simple 32-bit word-addressed register bus. The host first programs a trigger mask, a pattern, a trigger mode and a post-trigger sample count. It then arms the block, waits for the done flag and reads both buffers back through auto-incrementing pointers. Nothing streams out while the capture is running.

The control state machine has six states. IDLE leaves IDLE on an arm write (arm). ARMED samples and waits for the trigger condition (fire). POST samples the programmed number of further samples (post_spent). FLUSH writes the run that is still open (flush). SETTLE waits until the lane window has frozen (lanes_frozen). DONE holds until the next arm. An arm write in any state restarts the acquisition in ARMED.

Top module: `rle_capture_core`

## Requirements
- R1: After reset the status register (address 0) reads 0, `acq_done` is low and the entry-count register (address 8) reads 0.
- R2: Writing 1 to bit 0 of address 0 arms the block from any state. Arming clears the entry count, the wrap flag, the triggered flag and the done flag. While the block waits for a trigger, the status reads 0x1. The status bits are: bit0 waiting for trigger, bit1 triggered, bit2 done, bit3 buffer wrapped.
- R3: In pattern mode (mode register, address 3, value 0), the trigger fires on the first sample whose bits under the mask (address 1) equal the pattern (address 2). Bits outside the mask have no effect. Mode value 3 never fires.
- R4: In rising mode (value 1), the trigger fires when any masked bit goes from 0 to 1 between two consecutive samples. In falling mode (value 2), it fires when any masked bit goes from 1 to 0. The first sample after arming is never compared with samples taken before the arm.
- R5: Each stored entry holds an event value and a run length of at least 1. A new entry starts whenever the sampled value differs from the open run.
- R6: A run that reaches 2^CNT_W-1 samples is stored, and the next equal sample starts a new entry.
- R7: The trigger sample always starts a new entry. Address 9 returns the index of that entry.
- R8: After the trigger sample, exactly the number of samples written to address 4 is recorded. The open run is then stored, and no further entries are written until the next arm.
- R9: Address 5 sets and returns the event read index. Address 6 returns the value at that index. Address 7 returns the run length and advances the index by one. Read data appears with `reg_rvalid` one cycle after `reg_rd`.
- R10: Address 8 returns the write index (the number of stored entries, modulo the depth). Status bit3 is set once the event buffer has wrapped.
- R11: The lane buffer is written on every sample while waiting for the trigger, including the trigger sample, and on the next 2^(LANE_AW-1)-1 cycles after it. It then freezes. Address 12 returns the entry that holds the trigger sample.
- R12: Address 10 holds the lane read pointer, with the word index in bits [7:0] and the entry in bits [8+:LANE_AW]. Word w of an entry is lane bits [32w+31:32w]. A read of address 11 returns that word and advances the pointer, moving to word 0 of the next entry after the last word.
- R13: `acq_done` and status bit2 are set once the final run has been stored and the lanes have frozen. Both stay set until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| events_in | input | 8*EVT_BYTES | Event inputs, compressed and used for triggering |
| lanes_in | input | LANE_GROUPS*128 (min 1) | Wide uncompressed data lanes |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| acq_done | output | 1 | Acquisition complete |

## Verification
Three corner cases are hard to reach from the ports. The first is a run that saturates its counter. The second is an event buffer that wraps before the trigger. The third is a lane window whose post-trigger writes overwrite the oldest pre-trigger entry. The bench builds the core with a 4-bit run counter, a 32-entry event buffer and an 8-entry lane buffer. Holding an input steady for 20 samples then splits a run, and 34 alternating samples wrap the buffer. In a short pre-trigger phase, lane stamps that carry their sample number show exactly which entries survived the freeze.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_POST,
        ST_FLUSH,
        ST_SETTLE,
        ST_DONE
    } cap_state_t;

    typedef enum logic [1:0] {
        TM_LEVEL = 2'd0,
        TM_RISE  = 2'd1,
        TM_FALL  = 2'd2,
        TM_OFF   = 2'd3
    } trig_mode_t;

    localparam logic [3:0] RA_CTRL      = 4'd0;
    localparam logic [3:0] RA_MASK      = 4'd1;
    localparam logic [3:0] RA_PATTERN   = 4'd2;
    localparam logic [3:0] RA_MODE      = 4'd3;
    localparam logic [3:0] RA_POST      = 4'd4;
    localparam logic [3:0] RA_EVT_PTR   = 4'd5;
    localparam logic [3:0] RA_EVT_VAL   = 4'd6;
    localparam logic [3:0] RA_EVT_LEN   = 4'd7;
    localparam logic [3:0] RA_EVT_WPTR  = 4'd8;
    localparam logic [3:0] RA_TRIG_IDX  = 4'd9;
    localparam logic [3:0] RA_LANE_PTR  = 4'd10;
    localparam logic [3:0] RA_LANE_DATA = 4'd11;
    localparam logic [3:0] RA_LANE_TRIG = 4'd12;

endpackage

// File: rtl/cap_ram.sv
module cap_ram #(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cap_trigger.sv
module cap_trigger
    import cap_pkg::*;
#(
    parameter int W = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       sample_en,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] pattern,
    input  trig_mode_t mode,
    output logic       hit
);
    logic [W-1:0] prev;
    logic         prev_ok;

    // Previous sample is only trusted after one sample of the current run.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev    <= '0;
            prev_ok <= 1'b0;
        end else if (clear) begin
            prev_ok <= 1'b0;
        end else if (sample_en) begin
            prev    <= sample;
            prev_ok <= 1'b1;
        end
    end

    always_comb begin
        unique case (mode)
            TM_LEVEL: hit = ((sample ^ pattern) & mask) == '0;
            TM_RISE:  hit = prev_ok && (|(sample & ~prev & mask));
            TM_FALL:  hit = prev_ok && (|(~sample & prev & mask));
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cap_rle_packer.sv
module cap_rle_packer #(
    parameter int W  = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample_en,
    input  logic [W-1:0]  sample,
    input  logic          split,
    input  logic          flush,
    output logic          we,
    output logic [W-1:0]  wval,
    output logic [CW-1:0] wlen
);
    localparam logic [CW-1:0] LEN_MAX = {CW{1'b1}};

    logic [W-1:0]  run_val;
    logic [CW-1:0] run_len;
    logic          run_open;

    always_comb begin
        we = 1'b0;
        if (flush) begin
            we = run_open;
        end else if (sample_en && run_open) begin
            we = (sample != run_val) || (run_len == LEN_MAX) || split;
        end
        wval = run_val;
        wlen = run_len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_val  <= '0;
            run_len  <= '0;
            run_open <= 1'b0;
        end else if (clear || flush) begin
            run_open <= 1'b0;
        end else if (sample_en) begin
            if (!run_open || we) begin
                run_val  <= sample;
                run_len  <= {{(CW-1){1'b0}}, 1'b1};
                run_open <= 1'b1;
            end else begin
                run_len <= run_len + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cap_lane_window.sv
module cap_lane_window #(
    parameter int GROUPS = 1,
    parameter int AW     = 6,
    parameter int LW     = (GROUPS > 0) ? GROUPS * 128 : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          capture,
    input  logic          trig,
    input  logic [LW-1:0] lane_din,
    input  logic [AW-1:0] rd_entry,
    input  logic [7:0]    rd_word,
    output logic [31:0]   rd_data,
    output logic          frozen,
    output logic [AW-1:0] trig_ptr
);
    generate
        if (GROUPS == 0) begin : g_none
            logic unused_lane;
            assign unused_lane = ^{clk, rst_n, clear, capture, trig, lane_din, rd_entry, rd_word};
            assign rd_data  = '0;
            assign frozen   = 1'b1;
            assign trig_ptr = '0;
        end else begin : g_lanes
            localparam int WORDS = GROUPS * 4;
            localparam int HALF  = 1 << (AW - 1);
            localparam logic [AW-1:0] POST_LEFT = AW'(HALF - 1);

            logic [AW-1:0] wptr;
            logic [AW-1:0] left;
            logic [AW-1:0] tptr;
            logic          after;
            logic          frz;
            logic          we;
            logic [LW-1:0] row;

            assign we = !frz && (capture || (after && left != '0));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wptr  <= '0;
                    left  <= '0;
                    tptr  <= '0;
                    after <= 1'b0;
                    frz   <= 1'b0;
                end else if (clear) begin
                    wptr  <= '0;
                    left  <= '0;
                    after <= 1'b0;
                    frz   <= 1'b0;
                end else begin
                    if (we) wptr <= wptr + 1'b1;
                    if (trig && !after) begin
                        after <= 1'b1;
                        left  <= POST_LEFT;
                        tptr  <= wptr;
                    end else if (after && !frz) begin
                        if (left == '0) frz <= 1'b1;
                        else            left <= left - 1'b1;
                    end
                end
            end

            cap_ram #(.W(LW), .AW(AW)) u_lane_ram (
                .clk   (clk),
                .we    (we),
                .waddr (wptr),
                .wdata (lane_din),
                .raddr (rd_entry),
                .rdata (row)
            );

            always_comb begin
                rd_data = '0;
                for (int j = 0; j < WORDS; j++) begin
                    if (rd_word == 8'(j)) rd_data = row[j*32 +: 32];
                end
            end

            assign frozen   = frz;
            assign trig_ptr = tptr;
        end
    endgenerate
endmodule

// File: rtl/rle_capture_core.sv
module rle_capture_core
    import cap_pkg::*;
#(
    parameter int EVT_BYTES   = 4,
    parameter int CNT_W       = 16,
    parameter int EVT_AW      = 10,
    parameter int LANE_GROUPS = 1,
    parameter int LANE_AW     = 6,
    parameter int EW          = 8 * EVT_BYTES,
    parameter int LANE_W      = (LANE_GROUPS > 0) ? LANE_GROUPS * 128 : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EW-1:0]     events_in,
    input  logic [LANE_W-1:0] lanes_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              acq_done
);
    localparam int ENT_W      = EW + CNT_W;
    localparam int LANE_WORDS = (LANE_GROUPS > 0) ? LANE_GROUPS * 4 : 1;

    cap_state_t state, nxt;

    logic [EW-1:0]     cfg_mask, cfg_pat;
    trig_mode_t        cfg_mode;
    logic [31:0]       cfg_post;
    logic [31:0]       post_left;
    logic [EVT_AW-1:0] wptr, trig_ptr, evt_rptr;
    logic              wrapped, trig_seen;
    logic [LANE_AW-1:0] lane_rent;
    logic [7:0]        lane_rword;

    logic arm_wr, sample_en, flush, lane_cap, trig_fire, hit;
    logic ev_we;
    logic [EW-1:0]     ev_wval;
    logic [CNT_W-1:0]  ev_wcnt;
    logic [ENT_W-1:0]  ev_row;
    logic [31:0]       lane_word;
    logic              lane_frozen;
    logic [LANE_AW-1:0] lane_tptr;
    logic [31:0]       rd_mux;

    assign arm_wr = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = ST_IDLE;
            ST_ARMED:  if (trig_fire) nxt = ST_POST;
            ST_POST:   if (post_left == '0) nxt = ST_FLUSH;
            ST_FLUSH:  nxt = ST_SETTLE;
            ST_SETTLE: if (lane_frozen) nxt = ST_DONE;
            ST_DONE:   nxt = ST_DONE;
            default:   nxt = ST_IDLE;
        endcase
        if (arm_wr) nxt = ST_ARMED;
    end

    // State-decoded controls
    always_comb begin
        sample_en = 1'b0;
        flush     = 1'b0;
        lane_cap  = 1'b0;
        unique case (state)
            ST_ARMED: begin
                sample_en = !arm_wr;
                lane_cap  = !arm_wr;
            end
            ST_POST:  sample_en = !arm_wr && (post_left != '0);
            ST_FLUSH: flush     = !arm_wr;
            default: ;
        endcase
        trig_fire = lane_cap && hit;
        acq_done  = (state == ST_DONE);
    end

    cap_trigger #(.W(EW)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (arm_wr),
        .sample_en (sample_en),
        .sample    (events_in),
        .mask      (cfg_mask),
        .pattern   (cfg_pat),
        .mode      (cfg_mode),
        .hit       (hit)
    );

    cap_rle_packer #(.W(EW), .CW(CNT_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (arm_wr),
        .sample_en (sample_en),
        .sample    (events_in),
        .split     (trig_fire),
        .flush     (flush),
        .we        (ev_we),
        .wval      (ev_wval),
        .wlen      (ev_wcnt)
    );

    cap_ram #(.W(ENT_W), .AW(EVT_AW)) u_evt_ram (
        .clk   (clk),
        .we    (ev_we),
        .waddr (wptr),
        .wdata ({ev_wcnt, ev_wval}),
        .raddr (evt_rptr),
        .rdata (ev_row)
    );

    cap_lane_window #(.GROUPS(LANE_GROUPS), .AW(LANE_AW), .LW(LANE_W)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (arm_wr),
        .capture  (lane_cap),
        .trig     (trig_fire),
        .lane_din (lanes_in),
        .rd_entry (lane_rent),
        .rd_word  (lane_rword),
        .rd_data  (lane_word),
        .frozen   (lane_frozen),
        .trig_ptr (lane_tptr)
    );

    // Capture bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr      <= '0;
            wrapped   <= 1'b0;
            trig_seen <= 1'b0;
            trig_ptr  <= '0;
            post_left <= '0;
        end else if (arm_wr) begin
            wptr      <= '0;
            wrapped   <= 1'b0;
            trig_seen <= 1'b0;
            post_left <= '0;
        end else begin
            if (ev_we) begin
                wptr <= wptr + 1'b1;
                if (wptr == {EVT_AW{1'b1}}) wrapped <= 1'b1;
            end
            if (trig_fire) begin
                trig_seen <= 1'b1;
                trig_ptr  <= ev_we ? wptr + 1'b1 : wptr;
                post_left <= cfg_post;
            end else if (state == ST_POST && post_left != '0) begin
                post_left <= post_left - 32'd1;
            end
        end
    end

    // Register read multiplexer
    always_comb begin
        rd_mux = '0;
        unique case (reg_addr)
            RA_CTRL:      rd_mux = {28'd0, wrapped, state == ST_DONE, trig_seen, state == ST_ARMED};
            RA_MASK:      rd_mux = 32'(cfg_mask);
            RA_PATTERN:   rd_mux = 32'(cfg_pat);
            RA_MODE:      rd_mux = {30'd0, cfg_mode};
            RA_POST:      rd_mux = cfg_post;
            RA_EVT_PTR:   rd_mux = 32'(evt_rptr);
            RA_EVT_VAL:   rd_mux = 32'(ev_row[EW-1:0]);
            RA_EVT_LEN:   rd_mux = 32'(ev_row[ENT_W-1:EW]);
            RA_EVT_WPTR:  rd_mux = 32'(wptr);
            RA_TRIG_IDX:  rd_mux = 32'(trig_ptr);
            RA_LANE_PTR:  rd_mux = 32'({lane_rent, lane_rword});
            RA_LANE_DATA: rd_mux = lane_word;
            RA_LANE_TRIG: rd_mux = 32'(lane_tptr);
            default:      rd_mux = '0;
        endcase
    end

    // Register writes and read side effects
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_mask   <= '0;
            cfg_pat    <= '0;
            cfg_mode   <= TM_LEVEL;
            cfg_post   <= '0;
            evt_rptr   <= '0;
            lane_rent  <= '0;
            lane_rword <= '0;
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_wr) begin
                unique case (reg_addr)
                    RA_MASK:     cfg_mask <= reg_wdata[EW-1:0];
                    RA_PATTERN:  cfg_pat  <= reg_wdata[EW-1:0];
                    RA_MODE:     cfg_mode <= trig_mode_t'(reg_wdata[1:0]);
                    RA_POST:     cfg_post <= reg_wdata;
                    RA_EVT_PTR:  evt_rptr <= reg_wdata[EVT_AW-1:0];
                    RA_LANE_PTR: begin
                        lane_rent  <= reg_wdata[8 +: LANE_AW];
                        lane_rword <= (reg_wdata[7:0] < 8'(LANE_WORDS)) ? reg_wdata[7:0] : 8'd0;
                    end
                    default: ;
                endcase
            end
            if (reg_rd) begin
                reg_rdata <= rd_mux;
                if (reg_addr == RA_EVT_LEN) evt_rptr <= evt_rptr + 1'b1;
                if (reg_addr == RA_LANE_DATA) begin
                    if (lane_rword == 8'(LANE_WORDS - 1)) begin
                        lane_rword <= 8'd0;
                        lane_rent  <= lane_rent + 1'b1;
                    end else begin
                        lane_rword <= lane_rword + 8'd1;
                    end
                end
            end
        end
    end

    logic unused_bits;
    assign unused_bits = ^reg_wdata;
endmodule

// File: rtl/cap_checker.sv
module cap_checker
    import cap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_wr,
    input cap_state_t       state,
    input logic             ev_we,
    input logic [CNT_W-1:0] ev_wcnt,
    input logic             trig_seen,
    input logic             lane_frozen,
    input logic             acq_done
);
    // R5: every stored run covers at least one sample
    assert_run_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_we |-> ev_wcnt != '0);

    // R8: nothing is stored outside the capture and flush states
    assert_quiet_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_SETTLE || state == ST_DONE) |-> !ev_we);

    // R13: completion holds until re-armed
    assert_done_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_done && !arm_wr) |=> acq_done);

    // R7: the triggered flag only rises out of the waiting state
    assert_trig_from_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_seen) |-> $past(state) == ST_ARMED);

    // R11: a frozen lane window stays frozen until re-armed
    assert_lane_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_frozen && !arm_wr) |=> lane_frozen);
endmodule

bind rle_capture_core cap_checker #(.CNT_W(CNT_W)) u_cap_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_wr      (arm_wr),
    .state       (state),
    .ev_we       (ev_we),
    .ev_wcnt     (ev_wcnt),
    .trig_seen   (trig_seen),
    .lane_frozen (lane_frozen),
    .acq_done    (acq_done)
);

// File: tb/rle_capture_core_tb.sv
module rle_capture_core_tb_top;

    logic         clk;
    logic         rst_n;
    logic [15:0]  ev;
    logic [127:0] lanes;
    logic         reg_wr, reg_rd;
    logic [3:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata;
    logic         reg_rvalid;
    logic         acq_done;

    int n_chk  = 0;
    int n_fail = 0;
    int k      = 0;

    rle_capture_core #(
        .EVT_BYTES   (2),
        .CNT_W       (4),
        .EVT_AW      (5),
        .LANE_GROUPS (1),
        .LANE_AW     (3)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .events_in  (ev),
        .lanes_in   (lanes),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .acq_done   (acq_done)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        if (!reg_rvalid) begin
            n_chk++; n_fail++;
            $display("FAIL R9: actual rvalid 0 expected 1");
        end
        d = reg_rdata;
    endtask

    function automatic logic [127:0] stamp(input int n);
        logic [127:0] v;
        for (int j = 0; j < 4; j++) v[j*32 +: 32] = (32'(j) << 24) | 32'(n[15:0]);
        return v;
    endfunction

    task automatic tick(input logic [15:0] v);
        ev = v; lanes = stamp(k); k++;
        @(negedge clk);
    endtask

    task automatic wait_done(input logic [15:0] v);
        for (int i = 0; i < 200 && !acq_done; i++) tick(v);
        chk("R13 done flag", 32'(acq_done), 32'd1);
    endtask

    task automatic configure(input logic [31:0] m, input logic [31:0] p,
                             input logic [31:0] mode, input logic [31:0] post);
        reg_write(4'd1, m);
        reg_write(4'd2, p);
        reg_write(4'd3, mode);
        reg_write(4'd4, post);
    endtask

    task automatic entry(input string req, input int idx, input logic [31:0] v, input logic [31:0] n);
        logic [31:0] d;
        reg_write(4'd5, 32'(idx));
        reg_read(4'd6, d); chk({req, " value"}, d, v);
        reg_read(4'd7, d); chk({req, " length"}, d, n);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_read(4'd0, d); chk("R1 status after reset", d, 32'h0);
        chk("R1 done low", 32'(acq_done), 32'd0);
        reg_read(4'd8, d); chk("R1 entry count", d, 32'd0);
    endtask

    task automatic t_pattern();
        logic [31:0] d;
        int kt;
        configure(32'h00FF, 32'h0055, 32'd0, 32'd5);
        tick(16'h1100);
        reg_write(4'd0, 32'h1);
        for (int i = 0; i < 3; i++) tick(16'h1100);
        tick(16'h1200); tick(16'h1200);     // R3 upper byte masked out
        kt = k;
        tick(16'h3355);                     // trigger sample
        wait_done(16'h3300);
        reg_read(4'd0, d);  chk("R13 status triggered+done", d, 32'h6);
        reg_read(4'd8, d);  chk("R10 entry count", d, 32'd4);
        reg_read(4'd9, d);  chk("R7 trigger entry", d, 32'd2);
        entry("R5 run0", 0, 32'h1100, 32'd3);
        entry("R5 run1", 1, 32'h1200, 32'd2);
        entry("R7 trigger run", 2, 32'h3355, 32'd1);
        entry("R8 post run", 3, 32'h3300, 32'd5);
        reg_read(4'd5, d);  chk("R9 pointer advanced", d, 32'd4);
        // lanes
        reg_read(4'd12, d); chk("R11 lane trigger entry", d, 32'd5);
        reg_write(4'd10, 32'h0500);
        for (int j = 0; j < 4; j++) begin
            reg_read(4'd11, d); chk("R12 lane word", d, (32'(j) << 24) | 32'(kt));
        end
        reg_read(4'd11, d); chk("R12 lane next entry", d, 32'(kt + 1));
        reg_read(4'd10, d); chk("R12 lane pointer", d, 32'h0601);
        reg_write(4'd10, 32'h0400);
        reg_read(4'd11, d); chk("R11 pre-trigger sample", d, 32'(kt - 1));
        reg_write(4'd10, 32'h0100);
        reg_read(4'd11, d); chk("R11 oldest kept sample", d, 32'(kt - 4));
        reg_write(4'd10, 32'h0000);
        reg_read(4'd11, d); chk("R11 last post sample", d, 32'(kt + 3));
    endtask

    task automatic t_saturate();
        logic [31:0] d;
        configure(32'h0001, 32'h0001, 32'd0, 32'd0);
        tick(16'h0000);
        reg_write(4'd0, 32'h1);
        for (int i = 0; i < 20; i++) tick(16'h0000);
        tick(16'h0001);
        wait_done(16'h0001);
        entry("R6 saturated run", 0, 32'h0, 32'd15);
        entry("R6 remainder run", 1, 32'h0, 32'd5);
        entry("R8 zero post", 2, 32'h1, 32'd1);
        reg_read(4'd8, d); chk("R10 entry count", d, 32'd3);
        reg_read(4'd9, d); chk("R7 trigger entry", d, 32'd2);
    endtask

    task automatic t_rising();
        logic [31:0] d;
        configure(32'h0004, 32'h0, 32'd1, 32'd1);
        tick(16'h0004);
        reg_write(4'd0, 32'h1);
        tick(16'h0004); tick(16'h0004);     // R4 first sample not edge-compared
        tick(16'h0000); tick(16'h0000);
        tick(16'h0008); tick(16'h0008);     // R4 unmasked rise ignored
        tick(16'h000C);
        wait_done(16'h000C);
        reg_read(4'd9, d); chk("R4 rising trigger entry", d, 32'd3);
        entry("R4 first run", 0, 32'h4, 32'd2);
        entry("R4 ignored rise run", 2, 32'h8, 32'd2);
        entry("R4 trigger run", 3, 32'hC, 32'd2);
    endtask

    task automatic t_falling();
        logic [31:0] d;
        configure(32'h0100, 32'h0, 32'd2, 32'd2);
        tick(16'h0100);
        reg_write(4'd0, 32'h1);
        reg_read(4'd0, d); chk("R2 waiting status", d, 32'h1);
        tick(16'h0100); tick(16'h0100);
        tick(16'h0000);
        wait_done(16'h0000);
        reg_read(4'd9, d); chk("R4 falling trigger entry", d, 32'd1);
        entry("R4 falling pre run", 0, 32'h100, 32'd3);
        entry("R4 falling post run", 1, 32'h0, 32'd3);
        reg_read(4'd8, d); chk("R10 entry count", d, 32'd2);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        configure(32'h8000, 32'h8000, 32'd0, 32'd0);
        reg_write(4'd0, 32'h1);
        for (int i = 1; i <= 34; i++) tick((i % 2 == 1) ? 16'h0001 : 16'h0002);
        tick(16'h8000);
        wait_done(16'h8000);
        reg_read(4'd0, d); chk("R10 wrapped status", d, 32'hE);
        reg_read(4'd8, d); chk("R10 wrapped count", d, 32'd3);
        reg_read(4'd9, d); chk("R7 wrapped trigger entry", d, 32'd2);
        entry("R10 overwritten entry", 0, 32'h1, 32'd1);
        entry("R10 last pre run", 1, 32'h2, 32'd1);
        entry("R8 wrapped trigger run", 2, 32'h8000, 32'd1);
    endtask

    task automatic t_rearm();
        logic [31:0] d;
        reg_write(4'd3, 32'd3);
        reg_write(4'd0, 32'h1);
        reg_read(4'd0, d); chk("R2 re-arm status", d, 32'h1);
        reg_read(4'd8, d); chk("R2 count cleared", d, 32'd0);
        chk("R2 done cleared", 32'(acq_done), 32'd0);
        for (int i = 0; i < 5; i++) tick(16'hFFFF);
        reg_read(4'd0, d); chk("R3 mode 3 never fires", d, 32'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ev = '0; lanes = '0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pattern();
        t_saturate();
        t_rising();
        t_falling();
        t_wrap();
        t_rearm();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule